// File: doc/BRIEF.md
# Shared Prescaler Chain with Periodic Real-Time Interrupt

This block counts ticks of one selected source and feeds three consumers from the same counter. The source is either the real-time oscillator tick or the instruction-clock tick. Both arrive as single-cycle enables in the core clock domain, and a configuration input picks one of them as fS. The counter is a 15-stage ripple-free chain: an 8-stage divider low half and a 7-stage prescaler high half.

Two static selectors tap the chain for square-wave outputs. The first feeds the display driver. The second feeds the buzzer and sits one stage further down for the same code. A 3-bit software rate field picks which high stage produces the periodic real-time time-out.

Each time-out raises two flags: a timer sub-flag and a shared multi-function flag. Software clears each flag on its own. A vector request is presented only while the shared flag is set, the interrupt enable is on and the stack is not full. A new rate is read back at once, but it takes over only at the next time-out of the rate already in force. This means a period is never cut short and no spurious time-out is produced.

Top module: `mft_rtc_timer`

## Requirements
- R1: While rst_n is low and right after it: chain at zero, disp_out and buzz_out low, rtf and mff clear, rate_rd and the active rate equal to 3'b000.
- R2: With src_sel = 0 only instr_tick advances the chain; with src_sel = 1 only rtc_tick advances it; the other tick has no effect on any output.
- R3: The chain is 15 bits wide, advances by exactly one on each clock edge where the selected tick is high, holds otherwise, and wraps from all ones to zero.
- R4: disp_out equals chain bit k, where k = disp_sel (0..7). It is a 50% square wave with a period of 2^(k+1) fS ticks.
- R5: buzz_out equals chain bit k+1, where k = buzz_sel (0..7). It is a 50% square wave with a period of 2^(k+2) fS ticks.
- R6: With an active rate code c (0..7), a time-out occurs once per rising edge of chain bit c+7. The period is 2^(c+8) fS ticks: 256 for 3'b000 and 32768 for 3'b111.
- R7: A time-out seen in a cycle sets both rtf and mff at the next clock edge.
- R8: clr_rtf clears rtf and clr_mff clears mff at the next edge. When a time-out and a clear fall in the same cycle, the flag is set.
- R9: A write (rate_we with rate_wdata) shows on rate_rd after the next edge. The time-out period keeps the previous code until the next time-out of that code, and the written code governs from then on.
- R10: vec_req is high exactly when mff is high, emfi is high and stack_full is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 1 | fS source: 0 instruction tick, 1 real-time tick |
| instr_tick | input | 1 | Instruction-clock tick enable |
| rtc_tick | input | 1 | Real-time oscillator tick enable |
| disp_sel | input | 3 | Display tap code |
| buzz_sel | input | 3 | Buzzer tap code |
| rate_we | input | 1 | Rate field write strobe |
| rate_wdata | input | 3 | Rate code to write |
| clr_rtf | input | 1 | Clear timer sub-flag |
| clr_mff | input | 1 | Clear shared multi-function flag |
| emfi | input | 1 | Multi-function interrupt enable |
| stack_full | input | 1 | Stack-full indication |
| disp_out | output | 1 | Display-drive square wave |
| buzz_out | output | 1 | Buzzer square wave |
| rate_rd | output | 3 | Written rate code read-back |
| rtf | output | 1 | Timer sub-flag |
| mff | output | 1 | Shared multi-function flag |
| vec_req | output | 1 | Interrupt vector request |

## Verification
The bench builds the block with its default parameters: a 15-stage chain, 3-bit selectors and a prescaler base of 7. Ticks run at up to one per core cycle, so even the slowest code (32768 ticks) produces several time-outs within the run. Switching the rate between the fastest and slowest codes in the middle of a period shows that the hand-over waits for the old time-out. Sparse real-time ticks, with a busy instruction tick that is not selected, show the source choice. A clear held across a time-out exercises the set-over-clear priority.

// File: rtl/mft_pkg.sv
package mft_pkg;
    localparam int CHAIN_W  = 15;
    localparam int SEL_W    = 3;
    localparam int RTC_BASE = CHAIN_W - (1 << SEL_W);
    localparam int BUZZ_OFS = 1;

    typedef struct packed {
        logic [SEL_W-1:0] rate;
        logic [SEL_W-1:0] act;
        logic             prev;
        logic             rtf;
        logic             mff;
    } rtc_state_t;
endpackage

// File: rtl/mft_chain.sv
module mft_chain #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs_en,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (fs_en) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fs_en |=> cnt_q == $past(cnt_q) + W'(1));
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_en |=> $stable(cnt_q));
endmodule

// File: rtl/mft_tap.sv
module mft_tap #(
    parameter int W     = 15,
    parameter int SEL_W = 3,
    parameter int OFS   = 0
) (
    input  logic [W-1:0]     chain,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);
    localparam int NTAP = 1 << SEL_W;
    logic [NTAP-1:0] cand;

    for (genvar i = 0; i < NTAP; i++) begin : g_cand
        if (i + OFS < W) begin : g_in
            assign cand[i] = chain[i+OFS];
        end else begin : g_out
            assign cand[i] = 1'b0;
        end
    end

    assign tap = cand[sel];
endmodule

// File: rtl/mft_rtc_ctl.sv
module mft_rtc_ctl
    import mft_pkg::*;
#(
    parameter int W     = CHAIN_W,
    parameter int SW    = SEL_W,
    parameter int BASE  = RTC_BASE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  chain,
    input  logic          rate_we,
    input  logic [SW-1:0] rate_wdata,
    input  logic          clr_rtf,
    input  logic          clr_mff,
    output logic [SW-1:0] rate_rd,
    output logic          rtf,
    output logic          mff
);
    rtc_state_t st_d, st_q;
    logic       tap_now;
    logic       timeout;

    mft_tap #(.W(W), .SEL_W(SW), .OFS(BASE)) u_rtc_tap (
        .chain (chain),
        .sel   (st_q.act),
        .tap   (tap_now)
    );

    assign timeout = tap_now & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = tap_now;
        if (timeout) st_d.act  = st_q.rate;
        if (rate_we) st_d.rate = rate_wdata;
        if (timeout)      st_d.rtf = 1'b1;
        else if (clr_rtf) st_d.rtf = 1'b0;
        if (timeout)      st_d.mff = 1'b1;
        else if (clr_mff) st_d.mff = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rate_rd = st_q.rate;
    assign rtf     = st_q.rtf;
    assign mff     = st_q.mff;

    p_flags_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> st_q.rtf && st_q.mff);
    p_rate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !timeout |=> $stable(st_q.act));
    p_rate_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rate_we |=> st_q.rate == $past(rate_wdata));
    p_rtf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rtf && !timeout) |=> !st_q.rtf);
endmodule

// File: rtl/mft_rtc_timer.sv
module mft_rtc_timer
    import mft_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             instr_tick,
    input  logic             rtc_tick,
    input  logic [SEL_W-1:0] disp_sel,
    input  logic [SEL_W-1:0] buzz_sel,
    input  logic             rate_we,
    input  logic [SEL_W-1:0] rate_wdata,
    input  logic             clr_rtf,
    input  logic             clr_mff,
    input  logic             emfi,
    input  logic             stack_full,
    output logic             disp_out,
    output logic             buzz_out,
    output logic [SEL_W-1:0] rate_rd,
    output logic             rtf,
    output logic             mff,
    output logic             vec_req
);
    logic               fs_en;
    logic [CHAIN_W-1:0] chain;

    assign fs_en = src_sel ? rtc_tick : instr_tick;

    mft_chain #(.W(CHAIN_W)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .fs_en (fs_en),
        .cnt   (chain)
    );

    mft_tap #(.W(CHAIN_W), .SEL_W(SEL_W), .OFS(0)) u_disp_tap (
        .chain (chain),
        .sel   (disp_sel),
        .tap   (disp_out)
    );

    mft_tap #(.W(CHAIN_W), .SEL_W(SEL_W), .OFS(BUZZ_OFS)) u_buzz_tap (
        .chain (chain),
        .sel   (buzz_sel),
        .tap   (buzz_out)
    );

    mft_rtc_ctl #(.W(CHAIN_W), .SW(SEL_W), .BASE(RTC_BASE)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain      (chain),
        .rate_we    (rate_we),
        .rate_wdata (rate_wdata),
        .clr_rtf    (clr_rtf),
        .clr_mff    (clr_mff),
        .rate_rd    (rate_rd),
        .rtf        (rtf),
        .mff        (mff)
    );

    assign vec_req = mff & emfi & ~stack_full;

    p_vec_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> !stack_full && emfi && mff);
endmodule

// File: tb/tb_mft_rtc_timer.sv
module tb_mft_rtc_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_sel = 1'b0, instr_tick = 1'b0, rtc_tick = 1'b0;
    logic [2:0] disp_sel = 3'd0, buzz_sel = 3'd0;
    logic       rate_we = 1'b0;
    logic [2:0] rate_wdata = 3'd0;
    logic       clr_rtf = 1'b0, clr_mff = 1'b0, emfi = 1'b0, stack_full = 1'b0;
    logic       disp_out, buzz_out, rtf, mff, vec_req;
    logic [2:0] rate_rd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mft_rtc_timer dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .instr_tick(instr_tick),
        .rtc_tick(rtc_tick), .disp_sel(disp_sel), .buzz_sel(buzz_sel),
        .rate_we(rate_we), .rate_wdata(rate_wdata), .clr_rtf(clr_rtf),
        .clr_mff(clr_mff), .emfi(emfi), .stack_full(stack_full),
        .disp_out(disp_out), .buzz_out(buzz_out), .rate_rd(rate_rd),
        .rtf(rtf), .mff(mff), .vec_req(vec_req)
    );

    typedef struct packed {
        logic       disp;
        logic       buzz;
        logic       rtf;
        logic       mff;
        logic [2:0] rate;
    } exp_t;

    exp_t exp_q[$];

    logic [14:0] n_m;
    logic [2:0]  rate_m, act_m;
    logic        prev_m, rtf_m, mff_m;

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    // model from the requirements: push what the outputs must show after this edge
    always @(posedge clk) begin
        if (!rst_n) begin
            n_m = '0; rate_m = '0; act_m = '0; prev_m = 1'b0; rtf_m = 1'b0; mff_m = 1'b0;
        end else begin
            logic tap, tmo, fs;
            exp_t e;
            tap = n_m[int'(act_m) + 7];
            tmo = tap & ~prev_m;
            prev_m = tap;
            if (tmo) act_m = rate_m;
            if (rate_we) rate_m = rate_wdata;
            rtf_m = tmo ? 1'b1 : (clr_rtf ? 1'b0 : rtf_m);
            mff_m = tmo ? 1'b1 : (clr_mff ? 1'b0 : mff_m);
            fs = src_sel ? rtc_tick : instr_tick;
            if (fs) n_m = n_m + 15'd1;
            e.disp = n_m[disp_sel];
            e.buzz = n_m[int'(buzz_sel) + 1];
            e.rtf  = rtf_m;
            e.mff  = mff_m;
            e.rate = rate_m;
            exp_q.push_back(e);
        end
    end

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check("R4 disp_out", disp_out, e.disp);
            check("R5 buzz_out", buzz_out, e.buzz);
            check("R6/R7 rtf", rtf, e.rtf);
            check("R8 mff", mff, e.mff);
            check("R9 rate_rd", rate_rd, e.rate);
            check("R10 vec_req", vec_req, mff & emfi & ~stack_full);
        end
    end

    task automatic run(input int cyc, input int ip, input int rp, input int clr_every);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk); #1;
            instr_tick = (ip > 0) && (i % ip == 0);
            rtc_tick   = (rp > 0) && (i % rp == 0);
            clr_rtf    = (clr_every > 0) && (i % clr_every == 3);
            clr_mff    = (clr_every > 0) && (i % clr_every == 7);
            rate_we    = 1'b0;
        end
    endtask

    task automatic write_rate(input logic [2:0] v);
        @(negedge clk); #1;
        rate_we = 1'b1; rate_wdata = v;
        @(negedge clk); #1;
        rate_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 disp_out", disp_out, 0);
        check("R1 buzz_out", buzz_out, 0);
        check("R1 rtf", rtf, 0);
        check("R1 mff", mff, 0);
        check("R1 rate_rd", rate_rd, 0);
        #1; rst_n = 1'b1;
        // R2/R3/R4/R5/R6: instruction tick every cycle, real-time tick ignored
        src_sel = 1'b0; disp_sel = 3'd3; buzz_sel = 3'd0;
        run(700, 1, 2, 97);
        // R10 gating combinations with mff high
        run(300, 1, 0, 0);
        emfi = 1'b1; stack_full = 1'b0;
        @(negedge clk); check("R10 vec on", vec_req, mff ? 1 : 0);
        stack_full = 1'b1;
        @(negedge clk); check("R10 vec blocked", vec_req, 0);
        stack_full = 1'b0; emfi = 1'b0;
        @(negedge clk); check("R10 vec disabled", vec_req, 0);
        emfi = 1'b1;
        // R2: real-time source, sparse ticks, instruction tick busy but unused
        src_sel = 1'b1; disp_sel = 3'd7; buzz_sel = 3'd7;
        run(1600, 1, 3, 211);
        // R9: switch to slowest rate mid-period, old rate must finish first
        src_sel = 1'b0; disp_sel = 3'd5; buzz_sel = 3'd2;
        run(100, 1, 0, 0);
        write_rate(3'd7);
        run(70000, 1, 0, 4001);
        // R8: clear held through time-outs at a faster rate
        write_rate(3'd2);
        run(33000, 1, 0, 0);
        @(negedge clk); #1; clr_rtf = 1'b1; clr_mff = 1'b1;
        repeat (3000) @(negedge clk);
        #1; clr_rtf = 1'b0; clr_mff = 1'b0;
        run(1200, 1, 0, 0);
        // R3 wrap and R6 fastest code again
        write_rate(3'd0);
        run(33000, 1, 0, 503);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule